// File: doc/BRIEF.md
# Write-Through Data Cache Controller

This block sits between a 32-bit processor's data port and a memory bus that carries one request at a time and returns its data as a train of beats. The cache is direct-mapped, with a valid bit and a tag per line and a data array of whole lines. A cached read that hits gets its word in the same cycle, with no stall. A cached read that misses stalls the processor and refills the whole line with a burst. A read to an uncached segment also stalls, fetches one word, and never touches the array.

Writes are write-through and never allocate a line. Every write is pushed into an external write buffer, and the block holds the processor while that buffer is full. A write updates the array only when it is a cached write that hits. The processor can also clear one line with an invalidate command. Before any read goes to the bus, the controller waits until the write buffer reports that it is idle. Reads therefore never overtake earlier writes, and only one bus transaction is active at a time.

The read data and the stall toward the processor are combinational functions of the current request and the state.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid. The stall output is low while no request is presented, and the bus request and the buffer push are low.
- R2: A cached read (cpu_op = 0, cpu_uncached = 0) whose line is valid with a matching tag returns the stored word on cpu_rdata in the same cycle, with cpu_stall low.
- R3: A cached read miss holds cpu_stall high and raises mem_req with mem_burst = 1 and mem_addr set to the line base address. mem_req and mem_addr stay stable until mem_ack. The next WORDS beats fill word offsets 0 upward, after which the line is valid and the held read hits. The byte address splits, from the low bits, into 2 byte-offset bits, log2(WORDS) word bits, log2(LINES) index bits and the tag.
- R4: An uncached read (cpu_op = 0, cpu_uncached = 1) raises mem_req with mem_burst = 0 at the word-aligned address. It takes one beat, and the beat's data appears on cpu_rdata with cpu_stall low in the following cycle. It leaves the array unchanged and never hits.
- R5: A cached write (cpu_op = 1) pushes its address and data to the buffer in the cycle it is accepted. It updates the stored word only on a hit, and a write miss allocates nothing.
- R6: An uncached write is pushed to the buffer and leaves the array unchanged.
- R7: While wb_full is high, a write is stalled and nothing is pushed. The push happens in the first cycle in which wb_full is low.
- R8: An invalidate (cpu_op = 2) completes without a stall and clears the valid bit of the line selected by the address index. Other lines keep their state.
- R9: A read transaction is not requested on the bus until wb_idle has been seen high.
- R10: After mem_ack, mem_req stays low until every beat of that transaction has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_op | input | 2 | 0 read, 1 write, 2 invalidate line |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_uncached | input | 1 | Address lies in an uncached segment |
| cpu_rdata | output | 32 | Read data (combinational) |
| cpu_stall | output | 1 | Hold the processor (combinational) |
| wb_push | output | 1 | Write accepted into the write buffer |
| wb_addr | output | 32 | Write buffer address |
| wb_wdata | output | 32 | Write buffer data |
| wb_full | input | 1 | Write buffer cannot accept |
| wb_idle | input | 1 | Write buffer empty and no write in flight |
| mem_req | output | 1 | Read transaction request |
| mem_addr | output | 32 | Transaction start address |
| mem_burst | output | 1 | 1 line burst, 0 single word |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |

## Verification
The assertions assume that the processor holds its request, address and uncached flag stable while stalled. They also assume that the memory side sends mem_ack only against an active request, and sends exactly the expected number of beats only after that acknowledgement. The bench drives the processor one task per access and always keeps the request fixed until the stall drops. The memory model inside the read task acknowledges only a raised request and then sends one beat per cycle. wb_full and wb_idle are driven from countdowns and are never changed against a pending acknowledgement.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_INVAL = 2'd2,
    OP_NONE  = 2'd3
  } wtc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_REQ,
    ST_RECV,
    ST_RESP
  } wtc_state_e;

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES = 8,
  parameter int TB    = 25,
  localparam int IB   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IB-1:0] lk_idx,
  input  logic [TB-1:0] lk_tag,
  output logic          lk_hit,
  input  logic          inval_en,
  input  logic [IB-1:0] inval_idx,
  input  logic          fill_en,
  input  logic [IB-1:0] fill_idx,
  input  logic [TB-1:0] fill_tag
);

  logic [LINES-1:0] valid_vec;
  logic [LINES-1:0] hit_vec;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic          v_q;
    logic          v_d;
    logic          v_en;
    logic [TB-1:0] t_q;
    logic          set_l;
    logic          clr_l;

    always_comb begin
      set_l = fill_en  && (fill_idx  == IB'(l));
      clr_l = inval_en && (inval_idx == IB'(l));
      v_en  = set_l || clr_l;
      v_d   = set_l;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (v_en) begin
        v_q <= v_d;
      end
    end

    always_ff @(posedge clk) begin
      if (set_l) begin
        t_q <= fill_tag;
      end
    end

    assign valid_vec[l] = v_q;
    assign hit_vec[l]   = v_q && (t_q == lk_tag) && (lk_idx == IB'(l));
  end

  assign lk_hit = |hit_vec;

  // R3: a completed refill leaves its line valid
  p_fill_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_vec[$past(fill_idx)]);

  // R8: an invalidate leaves the addressed line invalid
  p_inval_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en && !fill_en) |=> !valid_vec[$past(inval_idx)]);

  // R1: coming out of reset no line is valid
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_vec == '0));

endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IB   = $clog2(LINES),
  localparam int WB   = $clog2(WORDS),
  localparam int ENTRIES = LINES * WORDS
) (
  input  logic          clk,
  input  logic [IB-1:0] rd_idx,
  input  logic [WB-1:0] rd_word,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IB-1:0] wr_idx,
  input  logic [WB-1:0] wr_word,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] mem_q [ENTRIES];
  logic [IB+WB-1:0] rd_sel;
  logic [IB+WB-1:0] wr_sel;

  assign rd_sel  = {rd_idx, rd_word};
  assign wr_sel  = {wr_idx, wr_word};
  assign rd_data = mem_q[rd_sel];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_sel] <= wr_data;
    end
  end

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int OFFB = 2,
  localparam int IB   = $clog2(LINES),
  localparam int WB   = $clog2(WORDS),
  localparam int TB   = 32 - OFFB - WB - IB,
  localparam logic [31:0] WORD_MASK = ~32'(3),
  localparam logic [31:0] LINE_MASK = ~32'((1 << (OFFB + WB)) - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  wtc_op_e       cpu_op,
  input  logic [31:0]   cpu_addr,
  input  logic          cpu_uncached,
  input  logic          lk_hit,
  input  logic          wb_full,
  input  logic          wb_idle,
  input  logic          mem_ack,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          cpu_stall,
  output logic          sel_hold,
  output logic [DW-1:0] hold_data,
  output logic          wb_push,
  output logic          hit_we,
  output logic          fill_we,
  output logic          fill_done,
  output logic [IB-1:0] fill_idx,
  output logic [TB-1:0] fill_tag,
  output logic [WB-1:0] fill_word,
  output logic          inval_en,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  output logic          mem_burst
);

  localparam logic [WB-1:0] LAST_WORD = WB'(WORDS - 1);

  wtc_state_e    state_q, state_d;
  logic [31:0]   miss_q;
  logic          unc_q;
  logic          miss_en;
  logic [WB-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [DW-1:0] hold_q;
  logic          hold_en;

  // next-state and output decode
  always_comb begin
    state_d   = state_q;
    cpu_stall = 1'b1;
    sel_hold  = 1'b0;
    wb_push   = 1'b0;
    hit_we    = 1'b0;
    fill_we   = 1'b0;
    fill_done = 1'b0;
    inval_en  = 1'b0;
    mem_req   = 1'b0;
    miss_en   = 1'b0;
    hold_en   = 1'b0;
    cnt_en    = 1'b0;
    cnt_d     = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cpu_stall = 1'b0;
        if (cpu_req) begin
          unique case (cpu_op)
            OP_READ: begin
              if (cpu_uncached || !lk_hit) begin
                cpu_stall = 1'b1;
                miss_en   = 1'b1;
                state_d   = ST_DRAIN;
              end
            end
            OP_WRITE: begin
              if (wb_full) begin
                cpu_stall = 1'b1;
              end else begin
                wb_push = 1'b1;
                hit_we  = !cpu_uncached && lk_hit;
              end
            end
            OP_INVAL: inval_en = 1'b1;
            default: ;
          endcase
        end
      end
      ST_DRAIN: begin
        if (wb_idle) state_d = ST_REQ;
      end
      ST_REQ: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          state_d = ST_RECV;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      ST_RECV: begin
        if (mem_rvalid) begin
          if (unc_q) begin
            hold_en = 1'b1;
            state_d = ST_RESP;
          end else begin
            fill_we = 1'b1;
            cnt_en  = 1'b1;
            cnt_d   = cnt_q + 1'b1;
            if (cnt_q == LAST_WORD) begin
              fill_done = 1'b1;
              state_d   = ST_IDLE;
            end
          end
        end
      end
      ST_RESP: begin
        cpu_stall = 1'b0;
        sel_hold  = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_en) begin
      miss_q <= cpu_addr;
      unc_q  <= cpu_uncached;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) begin
      hold_q <= mem_rdata;
    end
  end

  assign hold_data = hold_q;
  assign fill_idx  = miss_q[OFFB+WB +: IB];
  assign fill_tag  = miss_q[31 -: TB];
  assign fill_word = cnt_q;
  assign mem_burst = !unc_q;
  assign mem_addr  = unc_q ? (miss_q & WORD_MASK) : (miss_q & LINE_MASK);

  // R3: a bus request is held with a stable address until accepted
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_burst)));

  // R9: a read reaches the bus only after the write buffer reported idle
  p_drain_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(wb_idle));

  // R10: no new request while beats of the accepted one are still arriving
  p_one_txn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> !mem_req);

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wtc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  localparam int DW   = 32,
  localparam int OFFB = 2,
  localparam int IB   = $clog2(LINES),
  localparam int WB   = $clog2(WORDS),
  localparam int TB   = 32 - OFFB - WB - IB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [1:0]    cpu_op,
  input  logic [31:0]   cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_uncached,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_stall,
  output logic          wb_push,
  output logic [31:0]   wb_addr,
  output logic [DW-1:0] wb_wdata,
  input  logic          wb_full,
  input  logic          wb_idle,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  output logic          mem_burst,
  input  logic          mem_ack,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);

  wtc_op_e       op;
  logic [IB-1:0] cpu_idx;
  logic [WB-1:0] cpu_word;
  logic [TB-1:0] cpu_tag;
  logic          lk_hit;
  logic          sel_hold;
  logic [DW-1:0] hold_data;
  logic [DW-1:0] arr_rdata;
  logic          hit_we;
  logic          fill_we;
  logic          fill_done;
  logic [IB-1:0] fill_idx;
  logic [TB-1:0] fill_tag;
  logic [WB-1:0] fill_word;
  logic          inval_en;
  logic          arr_we;
  logic [IB-1:0] arr_widx;
  logic [WB-1:0] arr_wword;
  logic [DW-1:0] arr_wdata;

  assign op       = wtc_op_e'(cpu_op);
  assign cpu_word = cpu_addr[OFFB +: WB];
  assign cpu_idx  = cpu_addr[OFFB+WB +: IB];
  assign cpu_tag  = cpu_addr[31 -: TB];

  wtc_ctrl #(.LINES(LINES), .WORDS(WORDS), .DW(DW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_op       (op),
    .cpu_addr     (cpu_addr),
    .cpu_uncached (cpu_uncached),
    .lk_hit       (lk_hit),
    .wb_full      (wb_full),
    .wb_idle      (wb_idle),
    .mem_ack      (mem_ack),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .cpu_stall    (cpu_stall),
    .sel_hold     (sel_hold),
    .hold_data    (hold_data),
    .wb_push      (wb_push),
    .hit_we       (hit_we),
    .fill_we      (fill_we),
    .fill_done    (fill_done),
    .fill_idx     (fill_idx),
    .fill_tag     (fill_tag),
    .fill_word    (fill_word),
    .inval_en     (inval_en),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_burst    (mem_burst)
  );

  wtc_tag_store #(.LINES(LINES), .TB(TB)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (cpu_idx),
    .lk_tag    (cpu_tag),
    .lk_hit    (lk_hit),
    .inval_en  (inval_en),
    .inval_idx (cpu_idx),
    .fill_en   (fill_done),
    .fill_idx  (fill_idx),
    .fill_tag  (fill_tag)
  );

  // one array write port: refill beats and write hits never coincide
  always_comb begin
    arr_we    = fill_we || hit_we;
    arr_widx  = fill_we ? fill_idx  : cpu_idx;
    arr_wword = fill_we ? fill_word : cpu_word;
    arr_wdata = fill_we ? mem_rdata : cpu_wdata;
  end

  wtc_data_store #(.LINES(LINES), .WORDS(WORDS), .DW(DW)) u_data (
    .clk     (clk),
    .rd_idx  (cpu_idx),
    .rd_word (cpu_word),
    .rd_data (arr_rdata),
    .wr_en   (arr_we),
    .wr_idx  (arr_widx),
    .wr_word (arr_wword),
    .wr_data (arr_wdata)
  );

  assign cpu_rdata = sel_hold ? hold_data : arr_rdata;
  assign wb_addr   = cpu_addr;
  assign wb_wdata  = cpu_wdata;

  // R2: a cached read released from the array must be a hit
  p_cached_read_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && op == OP_READ && !cpu_uncached && !cpu_stall && !sel_hold) |-> lk_hit);

  // R7: nothing is pushed into a full buffer
  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_push |-> !wb_full);

  // R6: only write requests reach the write buffer
  p_push_is_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_push |-> (cpu_req && op == OP_WRITE));

endmodule

// File: tb/wt_dcache_bench.sv
module wt_dcache_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4;
  localparam int WORDS = 4;
  localparam int WDOG  = 20000;

  logic        clk;
  logic        rst_n;
  logic        cpu_req;
  logic [1:0]  cpu_op;
  logic [31:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_uncached;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        wb_push;
  logic [31:0] wb_addr;
  logic [31:0] wb_wdata;
  logic        wb_full;
  logic        wb_idle;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_burst;
  logic        mem_ack;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 0;
  logic [31:0] wmem [int unsigned];

  wt_dcache #(.LINES(LINES), .WORDS(WORDS)) u_wt_dcache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_uncached(cpu_uncached),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .wb_push(wb_push),
    .wb_addr(wb_addr), .wb_wdata(wb_wdata), .wb_full(wb_full),
    .wb_idle(wb_idle), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_burst(mem_burst), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(int tag, int idx, int w);
    return 32'((tag << 6) | (idx << 4) | (w << 2));
  endfunction

  function automatic logic [31:0] memval(logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [31:0] a, input bit unc, input int idle_wait,
                    output logic [31:0] d, output int nreq,
                    output logic [31:0] raddr, output bit rburst);
    int icnt = idle_wait;
    bit acked = 0;
    bit prev_idle = (idle_wait == 0);
    int nb = 0;
    int beat = 0;
    logic [31:0] base = '0;
    nreq = 0; raddr = '0; rburst = 0; d = '0;
    cpu_req = 1; cpu_op = 2'd0; cpu_addr = a; cpu_uncached = unc;
    for (int it = 0; it < 200; it++) begin
      mem_ack = 0; mem_rvalid = 0;
      if (acked && mem_req)
        chk(0, "R10", "request raised during open transaction", 32'(mem_req), 0);
      if (acked && beat < nb) begin
        mem_rvalid = 1;
        mem_rdata  = memval(base + 32'(4 * beat));
        beat++;
      end else if (mem_req && !acked) begin
        if (!prev_idle)
          chk(0, "R9", "request before buffer idle", 32'(prev_idle), 1);
        raddr = mem_addr; rburst = mem_burst;
        base = mem_addr; nb = mem_burst ? WORDS : 1;
        nreq++; acked = 1; mem_ack = 1;
      end
      wb_idle = (icnt == 0);
      prev_idle = wb_idle;
      if (icnt > 0) icnt--;
      #1;
      if (!cpu_stall) begin
        d = cpu_rdata;
        break;
      end
      @(posedge clk);
      #1;
    end
    step();
    cpu_req = 0; mem_ack = 0; mem_rvalid = 0; wb_idle = 1;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] v, input bit unc,
                    input int full_wait, output int stalls, output bit pushed,
                    output logic [31:0] paddr, output logic [31:0] pdata);
    int fcnt = full_wait;
    stalls = 0; pushed = 0; paddr = '0; pdata = '0;
    cpu_req = 1; cpu_op = 2'd1; cpu_addr = a; cpu_wdata = v; cpu_uncached = unc;
    for (int it = 0; it < 100; it++) begin
      wb_full = (fcnt > 0);
      #1;
      if (!cpu_stall) begin
        pushed = wb_push; paddr = wb_addr; pdata = wb_wdata;
        break;
      end
      if (wb_push) chk(0, "R7", "push while buffer full", 32'(wb_push), 0);
      stalls++;
      if (fcnt > 0) fcnt--;
      @(posedge clk);
      #1;
    end
    if (pushed) wmem[paddr] = pdata;
    step();
    cpu_req = 0; wb_full = 0;
  endtask

  task automatic inv(input logic [31:0] a);
    cpu_req = 1; cpu_op = 2'd2; cpu_addr = a; cpu_uncached = 0;
    #1;
    chk(cpu_stall == 0, "R8", "invalidate stalled", 32'(cpu_stall), 0);
    chk(wb_push == 0 && mem_req == 0, "R8", "invalidate caused traffic",
        32'({wb_push, mem_req}), 0);
    step();
    cpu_req = 0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WDOG, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ra, pa, pd, a, oldv, v;
    int nreq, st;
    bit rb, pu;
    rst_n = 0; cpu_req = 0; cpu_op = 0; cpu_addr = 0; cpu_wdata = 0;
    cpu_uncached = 0; wb_full = 0; wb_idle = 1; mem_ack = 0;
    mem_rvalid = 0; mem_rdata = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset outputs
    chk(cpu_stall == 0, "R1", "stall in reset", 32'(cpu_stall), 0);
    chk(mem_req == 0 && wb_push == 0, "R1", "traffic in reset", 32'({mem_req, wb_push}), 0);
    rst_n = 1;
    step();
    chk(cpu_stall == 0 && mem_req == 0, "R1", "idle after reset", 32'({cpu_stall, mem_req}), 0);

    // R1/R3/R9: every line misses first, refill by burst; R2: then all words hit
    for (int idx = 0; idx < LINES; idx++) begin
      a = mk(1, idx, 2);
      rd(a, 0, (idx % 3) + 1, d, nreq, ra, rb);
      chk(nreq == 1, "R1", "first read not a miss", 32'(nreq), 1);
      chk(rb == 1, "R3", "refill not a burst", 32'(rb), 1);
      chk(ra == mk(1, idx, 0), "R3", "refill address", ra, mk(1, idx, 0));
      chk(d == memval(a), "R3", "miss data", d, memval(a));
      for (int w = 0; w < WORDS; w++) begin
        a = mk(1, idx, w);
        rd(a, 0, 0, d, nreq, ra, rb);
        chk(nreq == 0, "R2", "hit went to bus", 32'(nreq), 0);
        chk(d == memval(a), "R2", "hit data", d, memval(a));
      end
    end

    // R3: conflicting tag evicts under direct mapping
    rd(mk(2, 1, 0), 0, 0, d, nreq, ra, rb);
    chk(nreq == 1 && d == memval(mk(2, 1, 0)), "R3", "conflict miss", d, memval(mk(2, 1, 0)));
    rd(mk(1, 1, 3), 0, 0, d, nreq, ra, rb);
    chk(nreq == 1, "R3", "evicted line still hit", 32'(nreq), 1);
    chk(d == memval(mk(1, 1, 3)), "R3", "reload data", d, memval(mk(1, 1, 3)));

    // R5: write hit updates line and buffer
    a = mk(1, 0, 2); v = 32'hC0DE0002;
    wr(a, v, 0, 0, st, pu, pa, pd);
    chk(pu == 1 && pa == a && pd == v, "R5", "write hit push", pd, v);
    rd(a, 0, 0, d, nreq, ra, rb);
    chk(nreq == 0 && d == v, "R5", "write hit readback", d, v);

    // R5: write miss allocates nothing
    a = mk(7, 3, 1); v = 32'hBEEF0701;
    wr(a, v, 0, 0, st, pu, pa, pd);
    chk(pu == 1 && pa == a, "R5", "write miss push", pa, a);
    rd(mk(1, 3, 1), 0, 0, d, nreq, ra, rb);
    chk(nreq == 0 && d == memval(mk(1, 3, 1)), "R5", "resident line disturbed", d, memval(mk(1, 3, 1)));
    rd(a, 0, 2, d, nreq, ra, rb);
    chk(nreq == 1 && d == v, "R5", "write miss allocated", d, v);

    // R4: uncached reads, one word, never hit, array untouched
    a = mk(3, 2, 3);
    rd(a, 1, 1, d, nreq, ra, rb);
    chk(nreq == 1 && rb == 0 && ra == a, "R4", "single word request", ra, a);
    chk(d == memval(a), "R4", "uncached data", d, memval(a));
    rd(a, 0, 0, d, nreq, ra, rb);
    chk(nreq == 1, "R4", "uncached read allocated", 32'(nreq), 1);
    a = mk(1, 0, 0);
    rd(a, 1, 0, d, nreq, ra, rb);
    chk(nreq == 1 && rb == 0, "R4", "uncached read hit", 32'(nreq), 1);

    // R6: uncached write to a resident word leaves the array copy
    a = mk(1, 0, 1); oldv = memval(a); v = 32'h0BAD0001;
    wr(a, v, 1, 0, st, pu, pa, pd);
    chk(pu == 1 && pd == v, "R6", "uncached write push", pd, v);
    rd(a, 0, 0, d, nreq, ra, rb);
    chk(nreq == 0 && d == oldv, "R6", "array changed", d, oldv);

    // R7: full buffer stalls a write
    for (int fw = 1; fw <= 3; fw++) begin
      a = mk(5, fw, 0); v = 32'hF0110000 + 32'(fw);
      wr(a, v, 0, fw, st, pu, pa, pd);
      chk(st == fw, "R7", "stall cycles", 32'(st), 32'(fw));
      chk(pu == 1 && pd == v, "R7", "push after full", pd, v);
    end

    // R8: invalidate one line only
    inv(mk(9, 0, 3));
    rd(mk(1, 0, 0), 0, 0, d, nreq, ra, rb);
    chk(nreq == 1, "R8", "invalidated line hit", 32'(nreq), 1);
    rd(mk(1, 1, 2), 0, 0, d, nreq, ra, rb);
    chk(nreq == 0 && d == memval(mk(1, 1, 2)), "R8", "other line lost", 32'(nreq), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule